// File: doc/BRIEF.md
# Byte-Serial Instruction Length Decoder

This block accepts machine code one byte per cycle and finds where each instruction ends. It covers a small 16-bit subset: one-byte register pushes, register/memory forms that carry an operand-descriptor byte, and a compare-with-constant form that adds a 16-bit constant. For each instruction it emits one record: the opcode, the three descriptor fields, the displacement, the constant and the total byte count.

A small state machine reads the opcode and then the two-bit addressing field of the descriptor byte. Together they decide how many more bytes to take. Multi-byte values arrive least significant byte first and are put together inside the block. An opcode outside the subset is reported as illegal and takes up exactly one byte, so decoding starts again at the byte after it. The input carries no backpressure: a byte is taken in every cycle that its valid strobe is high.

Top module: `ild_decode`

## Requirements
- R1: After reset, `out_valid` is low and the first byte accepted is treated as an opcode.
- R2: Opcodes 0x50 to 0x57 are one-byte pushes. `out_len` is 1 and `out_reg` carries opcode bits 2:0, with 0=AX, 1=CX, 2=DX, 3=BX, 4=SP, 5=BP, 6=SI, 7=DI. Mode, r/m, displacement and constant read zero.
- R3: Opcodes 0x89 and 0x8B, and every opcode with bits 7:6 = 00, bit 2 = 0 and bit 0 = 1, take one descriptor byte. That byte is split into mode = bits 7:6, reg = bits 5:3 and r/m = bits 2:0.
- R4: Mode 00 (memory, no offset) and mode 11 (register) take no displacement bytes. Without a constant the length is 2 and the displacement reads 0.
- R5: Mode 01 takes one displacement byte right after the descriptor. It is sign-extended to 16 bits and adds 1 to the length.
- R6: Mode 10 takes two displacement bytes right after the descriptor, low byte first. They add 2 to the length.
- R7: Opcode 0x81 takes a 16-bit constant after the descriptor and any displacement, low byte first, and adds 2 to the length. The stream 81 FA CD AB gives reg 7, r/m 2, constant 0xABCD and length 4. The stream 81 7E 08 CD AB gives mode 01, r/m 6, displacement 0x0008, constant 0xABCD and length 5.
- R8: Any other opcode gives a record with `out_illegal` high, length 1 and the opcode. The next byte is decoded as a fresh opcode.
- R9: `out_valid` is high for exactly one cycle per instruction, in the cycle after its last byte is accepted. Instructions may follow each other with no idle cycles.
- R10: Cycles with `in_valid` low, including cycles inside an instruction, change neither the decode nor the record that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is present on in_byte this cycle |
| in_byte | input | 8 | Machine code byte |
| out_valid | output | 1 | One-cycle strobe marking a decoded instruction |
| out_opcode | output | 8 | First byte of the instruction |
| out_mod | output | 2 | Addressing mode field |
| out_reg | output | 3 | Register field (push: register number) |
| out_rm | output | 3 | Register/memory field |
| out_disp | output | 16 | Displacement, sign-extended when one byte |
| out_imm | output | 16 | 16-bit constant |
| out_len | output | 3 | Instruction length in bytes, 1 to 6 |
| out_illegal | output | 1 | Opcode outside the supported subset |

## Verification
The bench drives every addressing mode, and a one-byte displacement with its top bit set, so that a decoder which zero-extends shows up as a wrong upper displacement byte. It sends the six-byte worst case, where a decoder that loses count of the displacement before the constant produces a shifted constant and a wrong length. It also sends long runs with no idle cycles and opcodes outside the subset placed between legal ones. A decoder that swallows extra bytes after an illegal opcode, or that drops a record on back-to-back pushes, then leaves expected records unmatched. Idle cycles are inserted inside instructions to catch a decoder that advances without a valid byte.

// File: rtl/ild_pkg.sv
package ild_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int LEN_W  = 3;

    typedef enum logic [1:0] {
        CLS_BAD,
        CLS_PUSH,
        CLS_RM,
        CLS_RM_IMM
    } op_class_e;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_MODRM,
        ST_DSP_LO,
        ST_DSP_HI,
        ST_IMM_LO,
        ST_IMM_HI
    } step_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] op;
        logic [1:0]        mode;
        logic [2:0]        reg_f;
        logic [2:0]        rm;
        logic [WORD_W-1:0] disp;
        logic [WORD_W-1:0] imm;
        logic [LEN_W-1:0]  len;
        logic              bad;
    } ins_rec_t;
endpackage

// File: rtl/ild_opclass.sv
module ild_opclass
    import ild_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output op_class_e         cls
);
    always_comb begin
        if (op[7:3] == 5'b01010) begin
            cls = CLS_PUSH;
        end else if (op == 8'h81) begin
            cls = CLS_RM_IMM;
        end else if (op == 8'h89 || op == 8'h8B) begin
            cls = CLS_RM;
        end else if (op[7:6] == 2'b00 && !op[2] && op[0]) begin
            cls = CLS_RM;
        end else begin
            cls = CLS_BAD;
        end
    end
endmodule

// File: rtl/ild_modrm_split.sv
module ild_modrm_split
    import ild_pkg::*;
(
    input  logic [BYTE_W-1:0] mrm,
    output logic [1:0]        mode,
    output logic [2:0]        reg_f,
    output logic [2:0]        rm,
    output logic [1:0]        dsp_bytes
);
    assign mode  = mrm[7:6];
    assign reg_f = mrm[5:3];
    assign rm    = mrm[2:0];

    always_comb begin
        unique case (mrm[7:6])
            2'b01:   dsp_bytes = 2'd1;
            2'b10:   dsp_bytes = 2'd2;
            default: dsp_bytes = 2'd0;
        endcase
    end
endmodule

// File: rtl/ild_sext.sv
module ild_sext #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  a,
    output logic [OUT_W-1:0] y
);
    assign y[IN_W-1:0] = a;
    for (genvar i = IN_W; i < OUT_W; i++) begin : g_ext
        assign y[i] = a[IN_W-1];
    end
endmodule

// File: rtl/ild_decode.sv
module ild_decode
    import ild_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    output logic [7:0]        out_opcode,
    output logic [1:0]        out_mod,
    output logic [2:0]        out_reg,
    output logic [2:0]        out_rm,
    output logic [15:0]       out_disp,
    output logic [15:0]       out_imm,
    output logic [2:0]        out_len,
    output logic              out_illegal
);
    typedef struct packed {
        step_e     st;
        op_class_e cls;
        ins_rec_t  work;
        ins_rec_t  rec;
    } dec_state_t;

    dec_state_t q, d;

    op_class_e         cls_in;
    logic [1:0]        mode_in;
    logic [2:0]        reg_in;
    logic [2:0]        rm_in;
    logic [1:0]        dsp_in;
    logic [WORD_W-1:0] dsp8_ext;
    logic              fin;

    ild_opclass u_cls (
        .op  (in_byte),
        .cls (cls_in)
    );

    ild_modrm_split u_split (
        .mrm       (in_byte),
        .mode      (mode_in),
        .reg_f     (reg_in),
        .rm        (rm_in),
        .dsp_bytes (dsp_in)
    );

    ild_sext #(.IN_W(BYTE_W), .OUT_W(WORD_W)) u_sext (
        .a (in_byte),
        .y (dsp8_ext)
    );

    always_comb begin
        d         = q;
        d.rec.vld = 1'b0;
        fin       = 1'b0;
        if (in_valid) begin
            case (q.st)
                ST_OPC: begin
                    d.work    = '0;
                    d.work.op = in_byte;
                    d.cls     = cls_in;
                    case (cls_in)
                        CLS_PUSH: begin
                            d.work.reg_f = in_byte[2:0];
                            d.work.len   = 3'd1;
                            fin          = 1'b1;
                        end
                        CLS_BAD: begin
                            d.work.bad = 1'b1;
                            d.work.len = 3'd1;
                            fin        = 1'b1;
                        end
                        default: d.st = ST_MODRM;
                    endcase
                end
                ST_MODRM: begin
                    d.work.mode  = mode_in;
                    d.work.reg_f = reg_in;
                    d.work.rm    = rm_in;
                    d.work.len   = 3'd2 + {1'b0, dsp_in}
                                 + ((q.cls == CLS_RM_IMM) ? 3'd2 : 3'd0);
                    if (dsp_in != 2'd0) begin
                        d.st = ST_DSP_LO;
                    end else if (q.cls == CLS_RM_IMM) begin
                        d.st = ST_IMM_LO;
                    end else begin
                        fin = 1'b1;
                    end
                end
                ST_DSP_LO: begin
                    if (q.work.mode == 2'b01) begin
                        d.work.disp = dsp8_ext;
                        if (q.cls == CLS_RM_IMM) begin
                            d.st = ST_IMM_LO;
                        end else begin
                            fin = 1'b1;
                        end
                    end else begin
                        d.work.disp[7:0] = in_byte;
                        d.st             = ST_DSP_HI;
                    end
                end
                ST_DSP_HI: begin
                    d.work.disp[15:8] = in_byte;
                    if (q.cls == CLS_RM_IMM) begin
                        d.st = ST_IMM_LO;
                    end else begin
                        fin = 1'b1;
                    end
                end
                ST_IMM_LO: begin
                    d.work.imm[7:0] = in_byte;
                    d.st            = ST_IMM_HI;
                end
                ST_IMM_HI: begin
                    d.work.imm[15:8] = in_byte;
                    fin              = 1'b1;
                end
                default: d.st = ST_OPC;
            endcase
        end
        if (fin) begin
            d.rec     = d.work;
            d.rec.vld = 1'b1;
            d.st      = ST_OPC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid   = q.rec.vld;
    assign out_opcode  = q.rec.op;
    assign out_mod     = q.rec.mode;
    assign out_reg     = q.rec.reg_f;
    assign out_rm      = q.rec.rm;
    assign out_disp    = q.rec.disp;
    assign out_imm     = q.rec.imm;
    assign out_len     = q.rec.len;
    assign out_illegal = q.rec.bad;
endmodule

// File: rtl/ild_decode_chk.sv
module ild_decode_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_valid,
    input logic [7:0]  out_opcode,
    input logic [1:0]  out_mod,
    input logic [15:0] out_disp,
    input logic [2:0]  out_len,
    input logic        out_illegal
);
    // R9: a record only appears right after an accepted byte
    a_r9_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R8: illegal opcodes occupy one byte and carry no operand data
    a_r8_bad_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_len == 3'd1 && out_mod == 2'b00 && out_disp == 16'h0));

    // R2: pushes are single byte and legal
    a_r2_push_len: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_opcode[7:3] == 5'b01010) |-> (out_len == 3'd1 && !out_illegal));

    // R5: one-byte displacement is sign-extended
    a_r5_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mod == 2'b01) |-> (out_disp[15:8] == {8{out_disp[7]}}));

    // R4: register or no-offset modes report zero displacement
    a_r4_no_disp: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_mod == 2'b00 || out_mod == 2'b11)) |-> (out_disp == 16'h0));

    // R7: constant form with register operand is four bytes
    a_r7_imm_len: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_opcode == 8'h81 && out_mod == 2'b11) |-> (out_len == 3'd4));

    // R9: a length is always within 1..6
    a_r9_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= 3'd1 && out_len <= 3'd6));
endmodule

bind ild_decode ild_decode_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_opcode  (out_opcode),
    .out_mod     (out_mod),
    .out_disp    (out_disp),
    .out_len     (out_len),
    .out_illegal (out_illegal)
);

// File: tb/ild_decode_test.sv
`timescale 1ns/1ps
module ild_decode_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic        out_valid;
    logic [7:0]  out_opcode;
    logic [1:0]  out_mod;
    logic [2:0]  out_reg;
    logic [2:0]  out_rm;
    logic [15:0] out_disp;
    logic [15:0] out_imm;
    logic [2:0]  out_len;
    logic        out_illegal;

    always #4 clk = ~clk;

    ild_decode uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_opcode(out_opcode), .out_mod(out_mod),
        .out_reg(out_reg), .out_rm(out_rm), .out_disp(out_disp),
        .out_imm(out_imm), .out_len(out_len), .out_illegal(out_illegal)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [1:0]  mode;
        logic [2:0]  rg;
        logic [2:0]  rm;
        logic [15:0] disp;
        logic [15:0] imm;
        logic [2:0]  len;
        logic        bad;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    task automatic expect_ins(input logic [7:0] op, input logic [1:0] mode,
                              input logic [2:0] rg, input logic [2:0] rm,
                              input logic [15:0] disp, input logic [15:0] imm,
                              input logic [2:0] len, input logic bad, input string tag);
        exp_t e;
        e.op = op; e.mode = mode; e.rg = rg; e.rm = rm;
        e.disp = disp; e.imm = imm; e.len = len; e.bad = bad;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic gap(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'hFF;
        end
    endtask

    task automatic push_reg(input logic [2:0] r);
        expect_ins({5'b01010, r}, 2'b00, r, 3'd0, 16'h0, 16'h0, 3'd1, 1'b0, "R2 R9 push");
        put({5'b01010, r});
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            exp_t got;
            got = {out_opcode, out_mod, out_reg, out_rm, out_disp, out_imm, out_len, out_illegal};
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R9 unexpected record: actual=%h expected=none", got);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (got !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual op=%h mod=%0d reg=%0d rm=%0d disp=%h imm=%h len=%0d ill=%0b expected op=%h mod=%0d reg=%0d rm=%0d disp=%h imm=%h len=%0d ill=%0b",
                             t, out_opcode, out_mod, out_reg, out_rm, out_disp, out_imm, out_len, out_illegal,
                             e.op, e.mode, e.rg, e.rm, e.disp, e.imm, e.len, e.bad);
                end
            end
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_byte  = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        gap(2);
        // R1: quiet after reset
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual out_valid=%b expected=0", out_valid);
        end

        // R1/R2: first byte is an opcode; all eight pushes back to back (R9)
        for (int r = 0; r < 8; r++) push_reg(3'(r));
        gap(2);

        // R3/R4: register mode and no-offset memory mode
        expect_ins(8'h89, 2'b11, 3'd3, 3'd0, 16'h0, 16'h0, 3'd2, 1'b0, "R3 R4 mode11");
        put(8'h89); put(8'hD8);
        expect_ins(8'h8B, 2'b00, 3'd0, 3'd7, 16'h0, 16'h0, 3'd2, 1'b0, "R3 R4 mode00");
        put(8'h8B); put(8'h07);
        gap(1);

        // R5: one-byte displacement, negative and positive
        expect_ins(8'h01, 2'b01, 3'd0, 3'd7, 16'hFFF0, 16'h0, 3'd3, 1'b0, "R5 sext negative");
        put(8'h01); put(8'h47); put(8'hF0);
        expect_ins(8'h3B, 2'b01, 3'd2, 3'd5, 16'h007F, 16'h0, 3'd3, 1'b0, "R5 sext positive");
        put(8'h3B); put(8'h55); put(8'h7F);
        gap(1);

        // R6: two-byte displacement, low byte first
        expect_ins(8'h29, 2'b10, 3'd0, 3'd6, 16'h1234, 16'h0, 3'd4, 1'b0, "R6 disp16");
        put(8'h29); put(8'h86); put(8'h34); put(8'h12);
        gap(1);

        // R7: the two stated constant-compare streams
        expect_ins(8'h81, 2'b11, 3'd7, 3'd2, 16'h0, 16'hABCD, 3'd4, 1'b0, "R7 cmp DX");
        put(8'h81); put(8'hFA); put(8'hCD); put(8'hAB);
        expect_ins(8'h81, 2'b01, 3'd7, 3'd6, 16'h0008, 16'hABCD, 3'd5, 1'b0, "R7 cmp [BP+8]");
        put(8'h81); put(8'h7E); put(8'h08); put(8'hCD); put(8'hAB);
        // R7/R6: six-byte worst case
        expect_ins(8'h81, 2'b10, 3'd7, 3'd6, 16'h1234, 16'hABCD, 3'd6, 1'b0, "R7 R6 six bytes");
        put(8'h81); put(8'hBE); put(8'h34); put(8'h12); put(8'hCD); put(8'hAB);
        expect_ins(8'h81, 2'b00, 3'd0, 3'd3, 16'h0, 16'h8001, 3'd4, 1'b0, "R7 R4 mode00 imm");
        put(8'h81); put(8'h03); put(8'h01); put(8'h80);
        gap(1);

        // R8: illegal opcodes resync at the next byte
        expect_ins(8'hFF, 2'b00, 3'd0, 3'd0, 16'h0, 16'h0, 3'd1, 1'b1, "R8 illegal FF");
        put(8'hFF);
        push_reg(3'd3);
        expect_ins(8'h8A, 2'b00, 3'd0, 3'd0, 16'h0, 16'h0, 3'd1, 1'b1, "R8 illegal 8A");
        put(8'h8A);
        expect_ins(8'h89, 2'b11, 3'd0, 3'd1, 16'h0, 16'h0, 3'd2, 1'b0, "R8 resync 89");
        put(8'h89); put(8'hC1);
        expect_ins(8'h02, 2'b00, 3'd0, 3'd0, 16'h0, 16'h0, 3'd1, 1'b1, "R8 illegal 02");
        put(8'h02);
        gap(2);

        // R10: idle cycles inside an instruction
        expect_ins(8'h81, 2'b01, 3'd0, 3'd6, 16'hFF80, 16'h2211, 3'd5, 1'b0, "R10 gaps");
        put(8'h81); gap(1); put(8'h46); gap(3); put(8'h80); gap(1);
        put(8'h11); gap(2); put(8'h22);
        gap(1);
        expect_ins(8'h31, 2'b10, 3'd1, 3'd1, 16'h8000, 16'h0, 3'd4, 1'b0, "R10 R6 gaps");
        put(8'h31); gap(2); put(8'h89); put(8'h00); gap(4); put(8'h80);
        gap(1);

        // R9: mixed stream with no idle cycles
        push_reg(3'd5);
        expect_ins(8'h81, 2'b11, 3'd7, 3'd0, 16'h0, 16'h00FF, 3'd4, 1'b0, "R9 mixed cmp");
        put(8'h81); put(8'hF8); put(8'hFF); put(8'h00);
        push_reg(3'd0);
        expect_ins(8'h03, 2'b01, 3'd1, 3'd4, 16'hFF80, 16'h0, 3'd3, 1'b0, "R9 mixed disp8");
        put(8'h03); put(8'h4C); put(8'h80);
        push_reg(3'd7);
        gap(4);

        // R9: every expected record was produced
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R9 missing records: actual pending=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule